// File: doc/BRIEF.md
# Serial/Parallel Flash Opcode Front End

This block sits on the device side of a flash memory bus and turns the first byte of every chip-select frame into a decoded command. In serial mode it shifts one opcode bit per rising edge of the bus clock, most significant bit first. In parallel mode it takes the whole opcode from an 8-bit data bus on the first rising bus-clock edge of the frame. Anything that follows the opcode in the same frame, such as address or data, is ignored here.

When chip select goes high, the captured opcode is checked against the command set that the current mode allows. The block then gives a single-cycle pulse on either a valid strobe or an illegal strobe. Two opcodes flip a sticky mode flag between serial and parallel. The flip takes effect only when the frame that carries the opcode closes. The flag keeps its value across any number of frames and is cleared only by the power-on reset. All bus lines are sampled with the block's system clock, and bus-clock and chip-select edges are found by comparing each line with its value one cycle earlier.

Top module: `fcf_cmd_frontend`

## Requirements
- R1: While `rst` is high and in the cycle after it, `par_mode`, `cmd_valid` and `cmd_illegal` are 0 and `cmd_code` is 0.
- R2: In serial mode (`par_mode`=0), `sdi` is sampled on the first eight rising `sck` edges while `cs_n` is low, MSB first. Bits on later edges of the same frame have no effect on the decoded command.
- R3: In parallel mode (`par_mode`=1), the opcode is `pdata` at the first rising `sck` edge of the frame. Values on later edges of the same frame have no effect. An `sck` rise in the same clock cycle as the fall of `cs_n` counts as that first edge.
- R4: In the clock cycle after `cs_n` is seen rising with a complete opcode, exactly one of `cmd_valid` and `cmd_illegal` is 1, for one cycle only. `cmd_code` carries the command: READ 0x03→1, FAST_READ 0x0B→2, WREN 0x06→3, WRDI 0x04→4, PP 0x02→5, SE 0xD8→6, BE 0xC7→7, WRSR 0x01→8, RDSR 0x05→9, RES 0xAB→10, DP 0xB9→11, RDID 0x9F→12, READ_ID 0x90→13, parallel entry 0x55→14, parallel exit 0x45→15.
- R5: An opcode not listed in R4 raises `cmd_illegal` and sets `cmd_code` to 0.
- R6: FAST_READ (0x0B) is valid in serial mode and illegal in parallel mode. When it is illegal, `cmd_code` is 0.
- R7: Opcode 0x55 sets `par_mode`. `par_mode` keeps its old value until `cs_n` rises, and becomes 1 in the same cycle as the valid strobe.
- R8: Opcode 0x45 clears `par_mode` in the same cycle as its valid strobe. In serial mode it is valid and leaves `par_mode` at 0.
- R9: If `cs_n` rises before a complete opcode has arrived (fewer than 8 edges in serial mode, none in parallel mode), no strobe is raised and `par_mode` is unchanged.
- R10: `par_mode` changes only in the cycle after a `cs_n` rise. It holds across frames until an R7/R8 opcode or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus lines |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Bus clock |
| sdi | input | 1 | Serial opcode bit |
| pdata | input | 8 | Parallel opcode byte |
| cmd_code | output | 4 | Decoded command code (R4 table) |
| cmd_valid | output | 1 | One-cycle pulse for an accepted command |
| cmd_illegal | output | 1 | One-cycle pulse for a rejected command |
| par_mode | output | 1 | 1 = parallel mode, 0 = serial mode |

## Verification
The valid strobe for a mode opcode and the change of the mode flag land in the same cycle. The bench sends the entry and exit opcodes and compares `par_mode` at the exact sample where the strobe appears. It also checks that the flag has not moved while chip select was still low. The bench then runs the next frame at once in the new capture width, so a flag that updates one cycle late, or too early, corrupts the following opcode. A second coincidence is also driven: the first bus-clock rise in the same system cycle as the chip-select fall. The parallel byte must then still be taken.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    localparam int OP_W = 8;

    typedef enum logic [3:0] {
        CMD_NONE      = 4'd0,
        CMD_READ      = 4'd1,
        CMD_FAST_READ = 4'd2,
        CMD_WREN      = 4'd3,
        CMD_WRDI      = 4'd4,
        CMD_PP        = 4'd5,
        CMD_SE        = 4'd6,
        CMD_BE        = 4'd7,
        CMD_WRSR      = 4'd8,
        CMD_RDSR      = 4'd9,
        CMD_RES       = 4'd10,
        CMD_DP        = 4'd11,
        CMD_RDID      = 4'd12,
        CMD_READ_ID   = 4'd13,
        CMD_PAR_ENTER = 4'd14,
        CMD_PAR_EXIT  = 4'd15
    } cmd_e;

    typedef struct packed {
        logic sck_rise;
        logic cs_fall;
        logic cs_rise;
    } bus_ev_t;

    typedef struct packed {
        logic            done;
        logic [OP_W-1:0] op;
    } op_cap_t;

    function automatic cmd_e op_decode(input logic [OP_W-1:0] op);
        case (op)
            8'h03:   return CMD_READ;
            8'h0B:   return CMD_FAST_READ;
            8'h06:   return CMD_WREN;
            8'h04:   return CMD_WRDI;
            8'h02:   return CMD_PP;
            8'hD8:   return CMD_SE;
            8'hC7:   return CMD_BE;
            8'h01:   return CMD_WRSR;
            8'h05:   return CMD_RDSR;
            8'hAB:   return CMD_RES;
            8'hB9:   return CMD_DP;
            8'h9F:   return CMD_RDID;
            8'h90:   return CMD_READ_ID;
            8'h55:   return CMD_PAR_ENTER;
            8'h45:   return CMD_PAR_EXIT;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic logic cmd_rejected(input cmd_e c, input logic par);
        return (c == CMD_NONE) || (par && (c == CMD_FAST_READ));
    endfunction

endpackage

// File: rtl/fcf_edges.sv
module fcf_edges
    import fcf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    cs_n,
    output bus_ev_t ev
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    always_comb begin
        ev.sck_rise = sck && !sck_q && !cs_n;
        ev.cs_fall  = !cs_n && cs_q;
        ev.cs_rise  = cs_n && !cs_q;
    end
endmodule

// File: rtl/fcf_capture.sv
module fcf_capture
    import fcf_pkg::*;
#(
    parameter int W         = OP_W,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_ev_t      ev,
    input  logic         par_mode,
    input  logic         sdi,
    input  logic [W-1:0] pdata,
    output logic         done,
    output logic [W-1:0] op
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sreg;
    logic [W-1:0]  shifted;
    logic [CW-1:0] cnt;

    generate
        if (MSB_FIRST) begin : g_msb
            assign shifted = {sreg[W-2:0], sdi};
        end else begin : g_lsb
            assign shifted = {sdi, sreg[W-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ev.cs_rise) begin
            sreg <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (ev.sck_rise && !done) begin
            if (par_mode) begin
                sreg <= pdata;
                done <= 1'b1;
            end else begin
                sreg <= shifted;
                cnt  <= cnt + 1'b1;
                done <= (cnt == LAST);
            end
        end
    end

    assign op = sreg;
endmodule

// File: rtl/fcf_mode_ctl.sv
module fcf_mode_ctl
    import fcf_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_ev_t      ev,
    input  logic         done,
    input  logic [W-1:0] op,
    output cmd_e         code,
    output logic         valid,
    output logic         illegal,
    output logic         par_mode
);
    cmd_e dec;
    logic bad;

    always_comb begin
        dec = op_decode(op);
        bad = cmd_rejected(dec, par_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code     <= CMD_NONE;
            valid    <= 1'b0;
            illegal  <= 1'b0;
            par_mode <= 1'b0;
        end else begin
            valid   <= 1'b0;
            illegal <= 1'b0;
            if (ev.cs_rise && done) begin
                valid   <= !bad;
                illegal <= bad;
                code    <= bad ? CMD_NONE : dec;
                if (!bad && dec == CMD_PAR_ENTER) par_mode <= 1'b1;
                if (!bad && dec == CMD_PAR_EXIT)  par_mode <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcf_cmd_frontend.sv
module fcf_cmd_frontend
    import fcf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            sdi,
    input  logic [OP_W-1:0] pdata,
    output logic [3:0]      cmd_code,
    output logic            cmd_valid,
    output logic            cmd_illegal,
    output logic            par_mode
);
    bus_ev_t ev;
    op_cap_t cap;
    cmd_e    code;

    fcf_edges u_edges (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .cs_n (cs_n),
        .ev   (ev)
    );

    fcf_capture #(.W(OP_W), .MSB_FIRST(1'b1)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .par_mode (par_mode),
        .sdi      (sdi),
        .pdata    (pdata),
        .done     (cap.done),
        .op       (cap.op)
    );

    fcf_mode_ctl #(.W(OP_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .done     (cap.done),
        .op       (cap.op),
        .code     (code),
        .valid    (cmd_valid),
        .illegal  (cmd_illegal),
        .par_mode (par_mode)
    );

    assign cmd_code = code;
endmodule

// File: rtl/fcf_checker.sv
module fcf_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic [3:0] cmd_code,
    input logic       cmd_valid,
    input logic       cmd_illegal,
    input logic       par_mode
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!par_mode && !cmd_valid && !cmd_illegal)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(cmd_valid && cmd_illegal)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid); // R4
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst) cmd_illegal |=> !cmd_illegal); // R4
    AST_STROBE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || cmd_illegal) |-> ($past(cs_n) && !$past(cs_n, 2))); // R4
    AST_ILLEGAL_CODE_ZERO: assert property (@(posedge clk) disable iff (rst) cmd_illegal |-> (cmd_code == 4'd0)); // R5
    AST_NO_FAST_READ_PAR: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !(par_mode && cmd_code == 4'd2)); // R6
    AST_ENTER_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'd14) |-> par_mode); // R7
    AST_EXIT_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'd15) |-> !par_mode); // R8
    AST_MODE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        (par_mode != $past(par_mode)) |-> ($past(cs_n) && !$past(cs_n, 2))); // R10
    AST_MODE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (par_mode != $past(par_mode)) |-> cmd_valid); // R9
endmodule

bind fcf_cmd_frontend fcf_checker u_fcf_checker (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .cmd_code    (cmd_code),
    .cmd_valid   (cmd_valid),
    .cmd_illegal (cmd_illegal),
    .par_mode    (par_mode)
);

// File: tb/fcf_cmd_frontend_bench.sv
module fcf_cmd_frontend_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] pdata = 8'h00;
    logic [3:0] cmd_code;
    logic       cmd_valid;
    logic       cmd_illegal;
    logic       par_mode;

    int checks = 0;
    int errors = 0;
    bit exp_mode = 1'b0;

    typedef struct {
        logic       v;
        logic       il;
        logic [3:0] code;
        logic       mode;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    fcf_cmd_frontend u_fcf_cmd_frontend (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sck         (sck),
        .sdi         (sdi),
        .pdata       (pdata),
        .cmd_code    (cmd_code),
        .cmd_valid   (cmd_valid),
        .cmd_illegal (cmd_illegal),
        .par_mode    (par_mode)
    );

    function automatic logic [3:0] exp_code(input logic [7:0] op);
        case (op)
            8'h03: return 4'd1;   8'h0B: return 4'd2;   8'h06: return 4'd3;
            8'h04: return 4'd4;   8'h02: return 4'd5;   8'hD8: return 4'd6;
            8'hC7: return 4'd7;   8'h01: return 4'd8;   8'h05: return 4'd9;
            8'hAB: return 4'd10;  8'hB9: return 4'd11;  8'h9F: return 4'd12;
            8'h90: return 4'd13;  8'h55: return 4'd14;  8'h45: return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard on each strobe
    always @(negedge clk) begin
        if (!rst && (cmd_valid || cmd_illegal)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe code", int'(cmd_code), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cmd_valid == e.v, e.req, "cmd_valid", int'(cmd_valid), int'(e.v));
                check(cmd_illegal == e.il, e.req, "cmd_illegal", int'(cmd_illegal), int'(e.il));
                check(cmd_code == e.code, e.req, "cmd_code", int'(cmd_code), int'(e.code));
                check(par_mode == e.mode, e.req, "par_mode at strobe", int'(par_mode), int'(e.mode));
            end
        end
    end

    // Driver: one chip-select frame with nclk bus-clock rises
    task automatic xfer(input logic [7:0] op, input int nclk, input bit early, input string req);
        bit         full;
        bit         bad;
        bit         mode0;
        bit         nmode;
        logic [3:0] c;
        mode0 = exp_mode;
        nmode = exp_mode;
        full  = exp_mode ? (nclk >= 1) : (nclk >= 8);
        if (full) begin
            c   = exp_code(op);
            bad = (c == 4'd0) || (exp_mode && c == 4'd2);
            if (!bad && c == 4'd14) nmode = 1'b1;
            if (!bad && c == 4'd15) nmode = 1'b0;
            sb.push_back('{!bad, bad, bad ? 4'd0 : c, nmode, req});
        end
        @(negedge clk);
        cs_n = 1'b0;
        for (int k = 0; k < nclk; k++) begin
            sdi   = (k < 8) ? op[7-k] : k[0];
            pdata = (k == 0) ? op : ~op;
            if (!(early && k == 0)) @(negedge clk);
            sck = 1'b1;
            @(negedge clk);
            @(negedge clk);
            sck = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        check(par_mode == mode0, "R7", "mode before cs rise", int'(par_mode), int'(mode0));
        cs_n = 1'b1;
        exp_mode = nmode;
        repeat (4) @(negedge clk);
        check(par_mode == exp_mode, "R10", "mode after frame", int'(par_mode), int'(exp_mode));
        check(sb.size() == 0, req, "pending strobes", sb.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cs_n = 1'b1;
        sck = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_mode = 1'b0;
        @(negedge clk);
        check(par_mode == 1'b0, "R1", "par_mode after reset", int'(par_mode), 0);
        check(!cmd_valid && !cmd_illegal, "R1", "strobes after reset", int'({cmd_valid, cmd_illegal}), 0);
        check(cmd_code == 4'd0, "R1", "cmd_code after reset", int'(cmd_code), 0);
    endtask

    initial begin
        logic [7:0] ops [13];
        ops = '{8'h03, 8'h0B, 8'h06, 8'h04, 8'h02, 8'hD8, 8'hC7,
                8'h01, 8'h05, 8'hAB, 8'hB9, 8'h9F, 8'h90};
        do_reset();
        xfer(8'h03, 8,  1'b0, "R2");   // serial READ
        xfer(8'h05, 12, 1'b0, "R2");   // trailing bits ignored
        xfer(8'h0B, 8,  1'b0, "R6");   // FAST_READ legal in serial
        xfer(8'h77, 8,  1'b0, "R5");   // unknown opcode
        xfer(8'h55, 5,  1'b0, "R9");   // short frame: nothing
        xfer(8'h45, 8,  1'b0, "R8");   // exit while serial
        xfer(8'h55, 16, 1'b0, "R7");   // enter parallel
        xfer(8'h02, 1,  1'b0, "R3");   // parallel PP
        xfer(8'hD8, 3,  1'b0, "R3");   // later bytes ignored
        xfer(8'h0B, 1,  1'b0, "R6");   // FAST_READ illegal in parallel
        xfer(8'hE3, 1,  1'b0, "R5");   // unknown in parallel
        xfer(8'h9F, 0,  1'b0, "R9");   // no byte at all
        xfer(8'h55, 1,  1'b0, "R10");  // enter again: stays parallel
        xfer(8'h90, 2,  1'b1, "R3");   // sck rise with cs fall
        for (int i = 0; i < 13; i++) xfer(ops[i], 1, 1'b0, "R4");
        xfer(8'h45, 1,  1'b1, "R8");   // exit from parallel
        xfer(8'hAB, 8,  1'b0, "R8");   // next frame serial again
        for (int i = 0; i < 13; i++) xfer(ops[i], 9, 1'b0, "R4");
        xfer(8'h55, 8,  1'b0, "R7");
        do_reset();                    // power cycle ends parallel mode
        xfer(8'hC7, 8,  1'b0, "R10");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule